// File: doc/BRIEF.md
# UART Interrupt and Trigger-Level Controller

This block raises the interrupt request of one serial channel and drives its receive-DMA busy line. It holds a 4-bit register of sticky interrupt sources and a 4-bit mask. A pending vector is derived from them: the sources that the mask lets through. The interrupt line is high while any pending bit is set.

The source bits are set by discrete events (a line error, a finished transmission, a modem-line change) and by level conditions. For the level conditions, the block compares the transmit and receive FIFO occupancy against trigger thresholds. Each threshold is a 3-bit control field multiplied by a scale factor. The scale is fixed per instance by the channel index, so one design serves channels with FIFOs of different depths. The receive threshold counts its field from one rather than zero.

When the FIFO is off, a single data-ready flag drives the receive source. Software clears sources through two write strobes, each carrying a bit vector with a 1 for every bit to clear.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit 0 is receive, bit 1 is error, bit 2 is transmit and bit 3 is modem. `errEvent` sets bit 1 and `modemEvent` sets bit 3 at the next rising clock edge. A set source bit stays set until it is cleared.
- R2: `wrMask` loads `wrData[3:0]` into `maskReg` at the next edge, and `maskReg` holds its value otherwise. `pendReg` always equals `srcPending & ~maskReg`.
- R3: `irq` is high exactly when `pendReg` is nonzero.
- R4: `wrSrcClr` and `wrPendClr` each clear, at the next edge, the source bits where `wrData` holds a 1. Pending bits follow the cleared sources. The clear leaves `maskReg` unchanged.
- R5: If a bit has a set condition and a clear in the same cycle, that bit is set after the edge.
- R6: With `fifoEn` high, bit 2 is set when `txCount <= txLevelSel * scale`. `txDoneEvent` sets bit 2 in either FIFO mode.
- R7: With `fifoEn` high, bit 0 is set when `rxCount >= (rxLevelSel + 1) * scale`.
- R8: With `fifoEn` high and `rxTimeoutEn` low, bit 0 is also set whenever `rxCount` is nonzero.
- R9: With `fifoEn` low, bit 0 is set whenever `dataReady` is high. In this mode the FIFO counts set no source bit.
- R10: The scale is 32 for `CHANNEL_IDX` 0, 8 for 1 and 4, and 2 for 2 and 3. Any other index gives a scale of 0, so both thresholds are 0.
- R11: `dmaBusy` is high exactly when `rxModeSel` equals 2'b10 and `rxCount` is 0. It is combinational in the same cycle.
- R12: While `rstN` is low, the source and mask registers are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | FIFO mode enable |
| rxTimeoutEn | input | 1 | Receive timeout enable; when low, any received data interrupts |
| rxModeSel | input | 2 | Receive service mode; 2'b10 selects DMA |
| txLevelSel | input | 3 | Transmit trigger field |
| rxLevelSel | input | 3 | Receive trigger field |
| txCount | input | CNT_W | Transmit FIFO occupancy |
| rxCount | input | CNT_W | Receive FIFO occupancy |
| dataReady | input | 1 | Receive holding register has data (FIFO off) |
| errEvent | input | 1 | Error event pulse |
| txDoneEvent | input | 1 | Transmit-complete pulse |
| modemEvent | input | 1 | Modem-line change pulse |
| wrSrcClr | input | 1 | Clear strobe aimed at the source register |
| wrPendClr | input | 1 | Clear strobe aimed at the pending register |
| wrMask | input | 1 | Mask write strobe |
| wrData | input | 4 | Write data for the three strobes |
| irq | output | 1 | Interrupt request |
| dmaBusy | output | 1 | Receive DMA busy |
| srcPending | output | 4 | Sticky source register |
| maskReg | output | 4 | Mask register |
| pendReg | output | 4 | Masked pending vector |

## Verification
Source, mask, pending and interrupt results are registered once. They are due one rising edge after the cycle in which the event, the level condition or the write strobe is presented. `dmaBusy` is combinational, so it is due in the same cycle as the count and mode inputs. The bench drives inputs and samples all outputs on the falling edge. At each rising edge its reference model advances using the inputs held since the previous falling edge, so every comparison lands half a cycle after the edge that produced the result. Three further instances, with channel indices 0, 2 and 5, share the stimulus so that every scale variant is compared.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_W   = 4;
  localparam int RX_BIT  = 0;
  localparam int ERR_BIT = 1;
  localparam int TX_BIT  = 2;
  localparam int MDM_BIT = 3;

  localparam logic [1:0] RX_MODE_DMA = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic [SRC_W-1:0] setVec;
    logic [SRC_W-1:0] clrVec;
    logic             maskWe;
    logic [SRC_W-1:0] maskVal;
  } irq_strobe_t;

  function automatic int channelScale(input int chanIdx);
    case (chanIdx)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL_IDX = 1,
  parameter int CNT_W       = 8
) (
  input  logic             fifoEn,
  input  logic             rxTimeoutEn,
  input  logic [1:0]       rxModeSel,
  input  logic [2:0]       txLevelSel,
  input  logic [2:0]       rxLevelSel,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             dataReady,
  input  logic             errEvent,
  input  logic             txDoneEvent,
  input  logic             modemEvent,
  input  logic             wrSrcClr,
  input  logic             wrPendClr,
  input  logic             wrMask,
  input  logic [SRC_W-1:0] wrData,
  output irq_strobe_t      strobe,
  output logic             dmaBusy
);
  localparam int LVL_W = CNT_W + 3;
  localparam int SCALE = channelScale(CHANNEL_IDX);
  localparam logic [LVL_W-1:0] SCALE_V = LVL_W'(SCALE);

  logic [LVL_W-1:0] txLvl;
  logic [LVL_W-1:0] rxLvl;
  logic [LVL_W-1:0] txCnt;
  logic [LVL_W-1:0] rxCnt;
  logic             rxHasData;
  logic             txBelow;
  logic             rxReached;
  logic             rxSetCond;

  assign txCnt = LVL_W'(txCount);
  assign rxCnt = LVL_W'(rxCount);

  // Trigger thresholds; receive field counts from one
  generate
    if (SCALE == 0) begin : g_noScale
      assign txLvl = '0;
      assign rxLvl = '0;
    end else begin : g_scaled
      assign txLvl = LVL_W'(txLevelSel) * SCALE_V;
      assign rxLvl = (LVL_W'(rxLevelSel) + LVL_W'(1)) * SCALE_V;
    end
  endgenerate

  assign rxHasData = (rxCount != '0);
  assign txBelow   = (txCnt <= txLvl);
  assign rxReached = (rxCnt >= rxLvl);

  always_comb begin
    if (fifoEn) begin
      rxSetCond = rxReached || (rxHasData && !rxTimeoutEn);
    end else begin
      rxSetCond = dataReady;
    end
  end

  always_comb begin
    strobe                 = '0;
    strobe.setVec[RX_BIT]  = rxSetCond;
    strobe.setVec[ERR_BIT] = errEvent;
    strobe.setVec[TX_BIT]  = txDoneEvent || (fifoEn && txBelow);
    strobe.setVec[MDM_BIT] = modemEvent;
    strobe.clrVec          = (wrSrcClr || wrPendClr) ? wrData : '0;
    strobe.maskWe          = wrMask;
    strobe.maskVal         = wrData;
  end

  assign dmaBusy = (rxModeSel == RX_MODE_DMA) && !rxHasData;
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irq_strobe_t      strobe,
  output logic [SRC_W-1:0] srcQ,
  output logic [SRC_W-1:0] maskQ,
  output logic [SRC_W-1:0] pendQ,
  output logic             irqQ
);
  // One sticky cell per source; set beats clear
  for (genvar b = 0; b < SRC_W; b++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcQ[b] <= 1'b0;
      end else begin
        srcQ[b] <= (srcQ[b] && !strobe.clrVec[b]) || strobe.setVec[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobe.maskWe) begin
      maskQ <= strobe.maskVal;
    end
  end

  assign pendQ = srcQ & ~maskQ;
  assign irqQ  = |pendQ;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL_IDX = 1,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             rxTimeoutEn,
  input  logic [1:0]       rxModeSel,
  input  logic [2:0]       txLevelSel,
  input  logic [2:0]       rxLevelSel,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             dataReady,
  input  logic             errEvent,
  input  logic             txDoneEvent,
  input  logic             modemEvent,
  input  logic             wrSrcClr,
  input  logic             wrPendClr,
  input  logic             wrMask,
  input  logic [3:0]       wrData,
  output logic             irq,
  output logic             dmaBusy,
  output logic [3:0]       srcPending,
  output logic [3:0]       maskReg,
  output logic [3:0]       pendReg
);
  irq_strobe_t strobe;

  uart_irq_ctl #(
    .CHANNEL_IDX(CHANNEL_IDX),
    .CNT_W      (CNT_W)
  ) ctl_i (
    .fifoEn     (fifoEn),
    .rxTimeoutEn(rxTimeoutEn),
    .rxModeSel  (rxModeSel),
    .txLevelSel (txLevelSel),
    .rxLevelSel (rxLevelSel),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .dataReady  (dataReady),
    .errEvent   (errEvent),
    .txDoneEvent(txDoneEvent),
    .modemEvent (modemEvent),
    .wrSrcClr   (wrSrcClr),
    .wrPendClr  (wrPendClr),
    .wrMask     (wrMask),
    .wrData     (wrData),
    .strobe     (strobe),
    .dmaBusy    (dmaBusy)
  );

  uart_irq_dp dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .srcQ  (srcPending),
    .maskQ (maskReg),
    .pendQ (pendReg),
    .irqQ  (irq)
  );
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic [1:0]       rxModeSel,
  input logic [CNT_W-1:0] rxCount,
  input logic             dataReady,
  input logic             errEvent,
  input logic             txDoneEvent,
  input logic             modemEvent,
  input logic             wrSrcClr,
  input logic             wrPendClr,
  input logic             wrMask,
  input logic [3:0]       wrData,
  input logic             irq,
  input logic             dmaBusy,
  input logic [3:0]       srcPending,
  input logic [3:0]       maskReg
);
  AST_MODEM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    modemEvent |=> srcPending[3]); // R1

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrSrcClr && !wrPendClr) |=> ((($past(srcPending)) & ~srcPending) == 4'h0)); // R1

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrMask |=> $stable(maskReg)); // R2

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == 4'hF) |-> !irq); // R3

  AST_ERR_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (errEvent && (wrSrcClr || wrPendClr) && wrData[1]) |=> srcPending[1]); // R5

  AST_TXDONE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    txDoneEvent |=> srcPending[2]); // R6

  AST_READY_NOFIFO: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && dataReady) |=> srcPending[0]); // R9

  AST_DMA_MODE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (rxModeSel != 2'b10) |-> !dmaBusy); // R11

  AST_DMA_DATA_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount != '0) |-> !dmaBusy); // R11
endmodule

bind uart_irq_ctrl uart_irq_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  localparam int CW = 8;
  localparam int NI = 4;
  localparam int CHAN [NI] = '{1, 0, 2, 5};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          fifoEn = 1'b0, rxTimeoutEn = 1'b1;
  logic [1:0]    rxModeSel = 2'b00;
  logic [2:0]    txLevelSel = 3'd0, rxLevelSel = 3'd0;
  logic [CW-1:0] txCount = 8'd255, rxCount = 8'd0;
  logic          dataReady = 1'b0, errEvent = 1'b0, txDoneEvent = 1'b0, modemEvent = 1'b0;
  logic          wrSrcClr = 1'b0, wrPendClr = 1'b0, wrMask = 1'b0;
  logic [3:0]    wrData = 4'h0;

  logic [3:0] srcO [NI];
  logic [3:0] maskO [NI];
  logic [3:0] pendO [NI];
  logic       irqO [NI];
  logic       dmaO [NI];

  uart_irq_ctrl #(.CHANNEL_IDX(CHAN[0]), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxTimeoutEn(rxTimeoutEn),
    .rxModeSel(rxModeSel), .txLevelSel(txLevelSel), .rxLevelSel(rxLevelSel),
    .txCount(txCount), .rxCount(rxCount), .dataReady(dataReady),
    .errEvent(errEvent), .txDoneEvent(txDoneEvent), .modemEvent(modemEvent),
    .wrSrcClr(wrSrcClr), .wrPendClr(wrPendClr), .wrMask(wrMask), .wrData(wrData),
    .irq(irqO[0]), .dmaBusy(dmaO[0]), .srcPending(srcO[0]), .maskReg(maskO[0]),
    .pendReg(pendO[0]));

  for (genvar k = 1; k < NI; k++) begin : g_ch
    uart_irq_ctrl #(.CHANNEL_IDX(CHAN[k]), .CNT_W(CW)) dutCh_i (
      .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .rxTimeoutEn(rxTimeoutEn),
      .rxModeSel(rxModeSel), .txLevelSel(txLevelSel), .rxLevelSel(rxLevelSel),
      .txCount(txCount), .rxCount(rxCount), .dataReady(dataReady),
      .errEvent(errEvent), .txDoneEvent(txDoneEvent), .modemEvent(modemEvent),
      .wrSrcClr(wrSrcClr), .wrPendClr(wrPendClr), .wrMask(wrMask), .wrData(wrData),
      .irq(irqO[k]), .dmaBusy(dmaO[k]), .srcPending(srcO[k]), .maskReg(maskO[k]),
      .pendReg(pendO[k]));
  end

  int    vecCnt = 0;
  int    badCnt = 0;
  bit    finished = 1'b0;
  string curReq = "R12";
  int    mSrc [NI];
  int    mMask;

  function automatic int scaleFor(input int ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  // Behavioural reference, advanced at every rising edge
  task automatic modelStep();
    if (!rstN) begin
      foreach (mSrc[k]) mSrc[k] = 0;
      mMask = 0;
      return;
    end
    for (int k = 0; k < NI; k++) begin
      int sc = scaleFor(CHAN[k]);
      int txLim = int'(txLevelSel) * sc;
      int rxLim = (int'(rxLevelSel) + 1) * sc;
      int nowSrc = mSrc[k];
      if (wrSrcClr || wrPendClr) nowSrc = nowSrc & ~int'(wrData);
      if (fifoEn) begin
        if (int'(rxCount) >= rxLim) nowSrc = nowSrc | 1;
        if (rxCount != 0 && !rxTimeoutEn) nowSrc = nowSrc | 1;
        if (int'(txCount) <= txLim) nowSrc = nowSrc | 4;
      end else if (dataReady) begin
        nowSrc = nowSrc | 1;
      end
      if (errEvent) nowSrc = nowSrc | 2;
      if (txDoneEvent) nowSrc = nowSrc | 4;
      if (modemEvent) nowSrc = nowSrc | 8;
      mSrc[k] = nowSrc & 15;
    end
    if (wrMask) mMask = int'(wrData);
  endtask

  task automatic check1(input int k, input string what, input int got, input int exp);
    vecCnt++;
    if (got != exp) begin
      badCnt++;
      $display("FAIL %s%s ch%0d %s got %0h exp %0h", curReq,
               (k != 0) ? " R10" : "", CHAN[k], what, got, exp);
    end
  endtask

  task automatic compareAll();
    for (int k = 0; k < NI; k++) begin
      int ePend = mSrc[k] & ~mMask & 15;
      check1(k, "srcPending", int'(srcO[k]), mSrc[k]);
      check1(k, "maskReg", int'(maskO[k]), mMask);
      check1(k, "pendReg", int'(pendO[k]), ePend);
      check1(k, "irq", int'(irqO[k]), (ePend != 0) ? 1 : 0);
      check1(k, "dmaBusy", int'(dmaO[k]),
             (rxModeSel == 2'b10 && rxCount == 0) ? 1 : 0);
    end
  endtask

  // One clock: model at the rising edge, compare at the falling edge
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      modelStep();
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic pulseClear(input bit viaPend, input logic [3:0] bits);
    wrData = bits;
    if (viaPend) wrPendClr = 1'b1; else wrSrcClr = 1'b1;
    tick();
    wrSrcClr = 1'b0; wrPendClr = 1'b0; wrData = 4'h0;
  endtask

  task automatic writeMask(input logic [3:0] m);
    wrData = m; wrMask = 1'b1;
    tick();
    wrMask = 1'b0; wrData = 4'h0;
  endtask

  initial begin
    foreach (mSrc[k]) mSrc[k] = 0;
    mMask = 0;
    // R12: reset state, with events pending during reset
    @(negedge clk);
    errEvent = 1'b1; modemEvent = 1'b1;
    tick(3);
    errEvent = 1'b0; modemEvent = 1'b0;
    rstN = 1'b1;
    tick();

    // R1: error and modem events set sticky bits
    curReq = "R1";
    errEvent = 1'b1; tick(); errEvent = 1'b0;
    tick(2);
    modemEvent = 1'b1; tick(); modemEvent = 1'b0;
    tick(2);

    // R2, R3: mask hides pending bits and the interrupt
    curReq = "R2";
    writeMask(4'h2);
    tick();
    curReq = "R3";
    writeMask(4'hF);
    tick(2);
    writeMask(4'h0);

    // R4: both clear strobes, mask kept
    curReq = "R4";
    writeMask(4'h4);
    pulseClear(1'b0, 4'h2);
    tick();
    pulseClear(1'b1, 4'h8);
    tick();
    writeMask(4'h0);

    // R5: set and clear in the same cycle
    curReq = "R5";
    errEvent = 1'b1; modemEvent = 1'b1;
    pulseClear(1'b1, 4'hF);
    errEvent = 1'b0; modemEvent = 1'b0;
    tick();
    pulseClear(1'b0, 4'hF);
    tick();

    // R6: transmit threshold and transmit-complete pulse
    curReq = "R6";
    txDoneEvent = 1'b1; tick(); txDoneEvent = 1'b0;
    pulseClear(1'b0, 4'hF);
    fifoEn = 1'b1; rxTimeoutEn = 1'b1; rxLevelSel = 3'd7; rxCount = 8'd0;
    txLevelSel = 3'd2;
    txCount = 8'd17; tick(2);
    pulseClear(1'b0, 4'hF);
    txCount = 8'd16; tick(2);
    txCount = 8'd200; pulseClear(1'b0, 4'hF);
    tick();
    txLevelSel = 3'd7; txCount = 8'd224; tick();
    txCount = 8'd255; pulseClear(1'b0, 4'hF);

    // R7: receive threshold counted from one
    curReq = "R7";
    rxLevelSel = 3'd1;
    rxCount = 8'd15; tick(2);
    pulseClear(1'b0, 4'hF);
    rxCount = 8'd16; tick(2);
    rxCount = 8'd0; pulseClear(1'b0, 4'hF);
    rxLevelSel = 3'd0; rxCount = 8'd2; tick();
    rxCount = 8'd0; pulseClear(1'b0, 4'hF);

    // R8: timeout disabled makes any data interrupt
    curReq = "R8";
    rxLevelSel = 3'd7; rxTimeoutEn = 1'b0;
    rxCount = 8'd1; tick(2);
    rxCount = 8'd0; pulseClear(1'b0, 4'hF);
    tick();
    rxTimeoutEn = 1'b1;

    // R9: FIFO off, data-ready drives receive, counts ignored
    curReq = "R9";
    fifoEn = 1'b0; txCount = 8'd0; rxCount = 8'd255; rxLevelSel = 3'd0;
    pulseClear(1'b0, 4'hF);
    tick(2);
    dataReady = 1'b1; tick(); dataReady = 1'b0;
    tick();
    pulseClear(1'b1, 4'h1);
    txCount = 8'd255;

    // R11: DMA busy decode
    curReq = "R11";
    rxCount = 8'd0;
    for (int m = 0; m < 4; m++) begin
      rxModeSel = 2'(m); tick();
    end
    rxModeSel = 2'b10; rxCount = 8'd3; tick();
    rxCount = 8'd0; tick();
    rxModeSel = 2'b00;

    // R10 and mixed traffic: shared stimulus over all scale variants
    curReq = "R10";
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom);
      fifoEn      = r[0];
      rxTimeoutEn = r[1];
      rxModeSel   = r[3:2];
      txLevelSel  = r[6:4];
      rxLevelSel  = r[9:7];
      txCount     = r[10] ? 8'(r[19:12]) : 8'(r[15:12]);
      rxCount     = r[11] ? 8'(r[27:20]) : 8'(r[22:20]);
      dataReady   = r[28];
      errEvent    = (r[31:29] == 3'd1);
      txDoneEvent = (r[31:29] == 3'd2);
      modemEvent  = (r[31:29] == 3'd3);
      wrData      = 4'(r[15:12] ^ r[7:4]);
      wrSrcClr    = (r[31:29] == 3'd4) || (r[31:29] == 3'd3);
      wrPendClr   = (r[31:29] == 3'd5);
      wrMask      = (r[31:29] == 3'd6);
      tick();
    end
    errEvent = 1'b0; txDoneEvent = 1'b0; modemEvent = 1'b0;
    wrSrcClr = 1'b0; wrPendClr = 1'b0; wrMask = 1'b0;
    tick();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      badCnt++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  end
endmodule